// File: doc/BRIEF.md
# Chainable Synchronous Binary Up-Counter

The block is a synchronous binary up-counter made of identical 4-bit stages. Each stage holds a nibble and has a synchronous clear, a synchronous parallel load and two count enables, a "prepare" enable and a "transfer" enable. The stage counts only when both enables are high. Each stage also produces a carry signal. The carry is high when the nibble holds its top value and the stage's transfer enable is high. The top module chains `STAGES` such stages, two by default, into one wider counter. Each stage's carry drives the transfer enable of the stage above it. Because of this, a carry crosses the whole chain inside one clock cycle.

Every update to the register takes place on the rising clock edge. This covers reset, clear, load and counting. The actions have a fixed priority. Clear comes first, load second and counting third. When none of them applies, the count holds its value. The carry of the top stage leaves the block so that a further counter can be chained to it in the same way.

Top module: `cnt_chain`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes 0 after that edge, and `carry_out` is then 0.
- R2: When `clr` and `load` are low and `en_p` and `en_t` are both high, each rising edge adds one to the full 8-bit count. The value 255 wraps to 0.
- R3: When `clr` and `load` are low and either `en_p` or `en_t` is low, the count keeps its value across the edge.
- R4: When `clr` is high at a rising edge, the count becomes 0. The values of `load`, `load_data` and the enables make no difference.
- R5: When `load` is high and `clr` is low at a rising edge, the count becomes `load_data`. The enables make no difference.
- R6: `carry_out` is high exactly when the count is 255 and `en_t` is high. This holds even when `en_p` is low.
- R7: The upper nibble (count bits 7:4) goes up by one on exactly the same edge at which the lower nibble (bits 3:0) counts from 15 to 0. On any other counting edge the upper nibble keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates occur on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous clear, highest priority |
| load | input | 1 | Synchronous parallel load |
| load_data | input | 8 | Value captured on a load edge |
| en_p | input | 1 | Count enable shared by all stages |
| en_t | input | 1 | Count enable of the lowest stage; also gates the carry |
| count | output | 8 | Current count value |
| carry_out | output | 1 | High when the count is at its top value and `en_t` is high |

## Verification
The rarest situation to reach is the nibble carry. The lower nibble has to be at 15 while both enables stay high and no clear or load arrives. The carry at the full-width top value, with `en_p` low, is also rare. Random traffic that mostly counts seldom gets there. Directed sequences therefore load values just under each boundary, such as 14, 254 and 255, and then count through or hold. The random phase keeps the enables high for about half of the cycles and also adds frequent loads. Each load places the counter at an arbitrary point, so the random counting passes through many nibble rollovers.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

    localparam int unsigned STAGE_W = 4;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } stage_act_e;

    typedef struct packed {
        logic clr;
        logic load;
        logic en_p;
        logic en_t;
    } stage_ctl_t;

    // Clear beats load, load beats counting, otherwise hold.
    function automatic stage_act_e pick_act(stage_ctl_t c);
        if (c.clr)
            return ACT_CLEAR;
        else if (c.load)
            return ACT_LOAD;
        else if (c.en_p && c.en_t)
            return ACT_COUNT;
        else
            return ACT_HOLD;
    endfunction

endpackage

// File: rtl/cnt_act_dec.sv
module cnt_act_dec
    import cnt_pkg::*;
(
    input  stage_ctl_t ctl,
    output stage_act_e act
);
    always_comb begin
        act = pick_act(ctl);
    end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
    import cnt_pkg::*;
#(
    parameter int unsigned W = STAGE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_ctl_t   ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] q,
    output logic         carry
);
    localparam logic [W-1:0] TOP_VAL = {W{1'b1}};

    stage_act_e   act;
    logic [W-1:0] q_next;

    cnt_act_dec u_dec (
        .ctl (ctl),
        .act (act)
    );

    always_comb begin
        unique case (act)
            ACT_CLEAR: q_next = '0;
            ACT_LOAD:  q_next = din;
            ACT_COUNT: q_next = q + W'(1);
            default:   q_next = q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_next;
    end

    // Carry gated by the transfer enable so it can ripple through a chain.
    assign carry = (q == TOP_VAL) && ctl.en_t;

endmodule

// File: rtl/cnt_chain.sv
module cnt_chain
    import cnt_pkg::*;
#(
    parameter int unsigned STAGES = 2,
    parameter int unsigned W      = STAGE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  load,
    input  logic [STAGES*W-1:0]   load_data,
    input  logic                  en_p,
    input  logic                  en_t,
    output logic [STAGES*W-1:0]   count,
    output logic                  carry_out
);
    localparam int unsigned TOTAL_W = STAGES * W;

    logic [STAGES:0] t_link;

    assign t_link[0] = en_t;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        stage_ctl_t   ctl;
        logic [W-1:0] q;

        always_comb begin
            ctl.clr  = clr;
            ctl.load = load;
            ctl.en_p = en_p;
            ctl.en_t = t_link[i];
        end

        cnt_stage #(.W(W)) u_stage (
            .clk   (clk),
            .rst   (rst),
            .ctl   (ctl),
            .din   (load_data[i*W +: W]),
            .q     (q),
            .carry (t_link[i+1])
        );

        assign count[i*W +: W] = q;
    end

    assign carry_out = t_link[STAGES];

endmodule

// File: rtl/cnt_chain_chk.sv
module cnt_chain_chk #(
    parameter int unsigned TOTAL_W = 8,
    parameter int unsigned W       = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               clr,
    input logic               load,
    input logic [TOTAL_W-1:0] load_data,
    input logic               en_p,
    input logic               en_t,
    input logic [TOTAL_W-1:0] count,
    input logic               carry_out
);
    logic counting;
    assign counting = !clr && !load && en_p && en_t;

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (count == '0));

    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        counting |=> (count == TOTAL_W'($past(count) + 1'b1)));

    assert_hold_value_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && !(en_p && en_t)) |=> $stable(count));

    assert_clear_zero_R4: assert property (@(posedge clk) disable iff (rst)
        clr |=> (count == '0));

    assert_load_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (!clr && load) |=> (count == $past(load_data)));

    assert_carry_gate_R6: assert property (@(posedge clk) disable iff (rst)
        carry_out == ((&count) && en_t));

    assert_upper_step_R7: assert property (@(posedge clk) disable iff (rst)
        (counting && (&count[W-1:0])) |=>
            (count[2*W-1:W] == W'($past(count[2*W-1:W]) + 1'b1)));

    assert_upper_still_R7: assert property (@(posedge clk) disable iff (rst)
        (counting && !(&count[W-1:0])) |=> $stable(count[2*W-1:W]));

endmodule

bind cnt_chain cnt_chain_chk #(.TOTAL_W(TOTAL_W), .W(W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .load      (load),
    .load_data (load_data),
    .en_p      (en_p),
    .en_t      (en_t),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/cnt_chain_tb_top.sv
module cnt_chain_tb_top;
    localparam int NW = 8;

    logic          clk = 1'b0;
    logic          rst, clr, load, en_p, en_t;
    logic [NW-1:0] load_data;
    logic [NW-1:0] count;
    logic          carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [NW-1:0] model;
    string         tag;

    always #2 clk = ~clk;

    cnt_chain dut_i (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .load      (load),
        .load_data (load_data),
        .en_p      (en_p),
        .en_t      (en_t),
        .count     (count),
        .carry_out (carry_out)
    );

    function automatic logic [NW-1:0] ref_next(logic [NW-1:0] cur, logic c,
                                               logic l, logic [NW-1:0] d,
                                               logic p, logic t);
        if (c)          return '0;
        else if (l)     return d;
        else if (p && t) return cur + 1'b1;
        else            return cur;
    endfunction

    function automatic string ref_tag(logic [NW-1:0] cur, logic c, logic l,
                                      logic p, logic t);
        if (c)           return "R4";
        else if (l)      return "R5";
        else if (p && t) return (cur[3:0] == 4'hF) ? "R7" : "R2";
        else             return "R3";
    endfunction

    task automatic check(string req, logic [NW-1:0] act, logic [NW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle: verify the value produced by the previous edge, apply
    // new inputs, verify the carry, then predict the next edge.
    task automatic step(logic c, logic l, logic [NW-1:0] d, logic p, logic t);
        @(negedge clk);
        check(tag, count, model);
        clr = c; load = l; load_data = d; en_p = p; en_t = t;
        #1;
        check("R6", {7'd0, carry_out}, {7'd0, (model == 8'hFF) && t});
        tag   = ref_tag(model, c, l, p, t);
        model = ref_next(model, c, l, d, p, t);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed = 32'd1234;
        void'($urandom(seed));
        rst = 1'b1; clr = 1'b0; load = 1'b0; en_p = 1'b0; en_t = 1'b0;
        load_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        tag   = "R1";
        // R1: reset state, carry low
        check("R1", count, 8'd0);
        check("R1", {7'd0, carry_out}, 8'd0);

        // R5 load just below a nibble boundary, then count through it (R7)
        step(1'b0, 1'b1, 8'h3E, 1'b0, 1'b0);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        // R3 hold with each enable low in turn
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        // R6 top value: carry with en_p low, no carry with en_t low
        step(1'b0, 1'b1, 8'hFF, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b0);
        // R2 full wrap 255 to 0
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b1, 1'b1);
        // R4 clear beats load and counting
        step(1'b0, 1'b1, 8'hA7, 1'b0, 1'b0);
        step(1'b1, 1'b1, 8'h55, 1'b1, 1'b1);
        // R5 load beats counting
        step(1'b0, 1'b1, 8'h9C, 1'b1, 1'b1);
        step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0);

        for (int i = 0; i < 4000; i++) begin
            int unsigned r = $urandom_range(0, 99);
            logic c = (r < 4);
            logic l = (r >= 4 && r < 14);
            logic [NW-1:0] d = NW'($urandom_range(0, 255));
            logic p = ($urandom_range(0, 99) < 75);
            logic t = ($urandom_range(0, 99) < 75);
            if (l && $urandom_range(0, 3) == 0)
                d = {d[7:4], 4'hE};
            step(c, l, d, p, t);
        end
        @(negedge clk);
        check(tag, count, model);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule